// File: doc/BRIEF.md
# Cascadable Match-Compare Timer Pair

This block holds two 8-bit up-counting timer channels. Each channel has its own counter, its own compare value and its own match interrupt. When a counter reaches its compare value it returns to zero on the following count step. The interrupt is a pulse one system clock wide. A join bit fuses the two channels into one 16-bit timer. In that mode channel 0 holds the low byte and channel 1 the high byte, and the match pulse comes out on channel 1's interrupt.

Each channel picks its count source from a slow clock, a fast clock or an external pin, then divides it by a power of two from 1 to 64. The external pin first passes through a two-flop synchronizer. Only rising edges of the selected source are counted. The whole block runs on one system clock: the divided edge acts as a clock enable.

Software works through a small byte-wide register port. It can write control, compare and counter registers, use separate start and stop strobes, and read back a running-status byte. Each channel has a two-state run machine. It moves from `ST_IDLE` to `ST_COUNT` on a start strobe and back from `ST_COUNT` to `ST_IDLE` on a stop strobe. In every other case it stays where it is.

Top module: `match_timer_pair`

## Requirements
- R1: After reset both counters, compare values and control bytes are 0, both channels are stopped (status reads 0) and both interrupt outputs are low.
- R2: In 8-bit mode a running channel adds 1 to its counter on each divided count edge. On the edge after the counter equals its compare value it reloads 0 instead, so one period is compare+1 count edges.
- R3: The interrupt of a channel is high for exactly one system clock. That clock is the one that follows the count edge that made the counter equal to the compare value.
- R4: The control field bits [1:0] select the source: 0 slow clock, 1 fast clock, 2 the channel's external pin (synchronized through two flops), 3 is treated as slow clock. Only rising edges of the source count.
- R5: The control field bits [4:2] hold a value n. For n from 0 to 6 the source is divided by 2^n. The value 7 divides by 1.
- R6: With bit 7 of control register 0 set, the pair forms a 16-bit counter {counter1, counter0} compared against {data1, data0}. The wrap and the pulse follow R2 and R3 on 16 bits. The pulse is on interrupt 1, and interrupt 0 stays low.
- R7: Writing any value to a counter register clears that counter to 0, and the clear takes priority over counting. In 16-bit mode a write to either counter byte clears both bytes.
- R8: A write to address 6 with bit i set starts channel i. A write to address 7 with bit i set stops channel i. Status at address 8 shows channel i running in bit i. A stopped channel's counter holds its value.
- R9: In 16-bit mode the channel-0 start and stop bits run the pair, and the channel-1 start and stop bits have no effect.
- R10: Register map: 0 and 1 are control for channel 0 and 1; 2 and 3 are compare data; 4 and 5 are counters. Every register reads back its value. Addresses 6 and 7 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk_i | input | 1 | Slow count source, level in the system clock domain |
| fast_clk_i | input | 1 | Fast count source, level in the system clock domain |
| ext_clk_i | input | 2 | External count pin per channel, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 2 | Match pulse per channel |

## Verification
The bench runs the timers with several source and divider settings. It uses the fast source at divide-by-1 and divide-by-2 and the reserved divider code. It also uses the external pin at divide-by-4 and the reserved source code. The intervals between interrupts come out different for each setting, so a wrong mux leg or a wrong divider tap shows up as a wrong period. A 16-bit run with a high compare byte of 1 checks the carry from the low byte into the high byte: a period of 301 edges cannot be reached by either byte alone. Clear, stop and ignored-strobe sequences are each followed by read-backs. A cycle-by-cycle behavioural model is compared against the interrupts and read data on every clock.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
    localparam int NCH = 2;
    localparam int A_CTRL0  = 0;
    localparam int A_DATA0  = 2;
    localparam int A_CNT0   = 4;
    localparam int A_START  = 6;
    localparam int A_STOP   = 7;
    localparam int A_STATUS = 8;
    localparam int JOIN_BIT = 7;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pair_pkg::*;
#(
    parameter int MAX_EXP = 6,
    parameter int DIV_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_i,
    input  logic             fast_i,
    input  logic             ext_i,
    input  src_e             src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             clr_i,
    output logic             tick_en_o
);
    logic               ext_s1, ext_s2, sel_q, sel_now, tick;
    logic [MAX_EXP-1:0] pre_q, mask;

    always_comb begin
        unique case (src_sel)
            SRC_FAST: sel_now = fast_i;
            SRC_EXT:  sel_now = ext_s2;
            default:  sel_now = slow_i;
        endcase
    end

    always_comb begin
        for (int b = 0; b < MAX_EXP; b++)
            mask[b] = (int'(div_sel) <= MAX_EXP) && (b < int'(div_sel));
    end

    assign tick      = sel_now & ~sel_q;
    assign tick_en_o = tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            sel_q  <= 1'b0;
            pre_q  <= '0;
        end else begin
            ext_s1 <= ext_i;
            ext_s2 <= ext_s1;
            sel_q  <= sel_now;
            if (clr_i)     pre_q <= '0;
            else if (tick) pre_q <= pre_q + 1'b1;
        end
    end

    // R3: two enables never come back to back, since an edge needs a low sample first
    p_enable_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en_o |=> !tick_en_o);
endmodule

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o
);
    run_st_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_nx = ST_COUNT;
            ST_COUNT: if (stop_i)  state_nx = ST_IDLE;
        endcase
    end

    always_comb run_o = (state_q == ST_COUNT);

    p_leave_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !stop_i) |=> state_q == ST_COUNT);
    p_enter_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
endmodule

// File: rtl/match_timer_pair.sv
module match_timer_pair
    import tmr_pair_pkg::*;
#(
    parameter int CW      = 8,
    parameter int AW      = 4,
    parameter int MAX_EXP = 6,
    parameter int DIV_W   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slow_clk_i,
    input  logic           fast_clk_i,
    input  logic [NCH-1:0] ext_clk_i,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [CW-1:0]  wdata_i,
    output logic [CW-1:0]  rdata_o,
    output logic [NCH-1:0] irq_o
);
    localparam int DW = 2 * CW;

    logic [CW-1:0]  ctrl_q [NCH];
    logic [CW-1:0]  data_q [NCH];
    logic [CW-1:0]  cnt_q  [NCH];
    logic [CW-1:0]  cnt_nx [NCH];
    logic [NCH-1:0] run, tick_en, wr_cnt, start_req, stop_req, irq_q, irq_nx;
    logic           join_w;
    logic [DW-1:0]  c16, d16, n16;
    logic [CW-1:0]  n8;

    assign join_w = ctrl_q[0][JOIN_BIT];

    // register decode; channel 1 strobes are masked while joined (R9)
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            wr_cnt[i]    = wr_en_i && (addr_i == AW'(A_CNT0 + i));
            start_req[i] = wr_en_i && (addr_i == AW'(A_START)) && wdata_i[i] && !(i > 0 && join_w);
            stop_req[i]  = wr_en_i && (addr_i == AW'(A_STOP))  && wdata_i[i] && !(i > 0 && join_w);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_run_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_req[g]),
            .stop_i  (stop_req[g]),
            .run_o   (run[g])
        );
        tmr_prescale #(.MAX_EXP(MAX_EXP), .DIV_W(DIV_W)) u_pre (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_i    (slow_clk_i),
            .fast_i    (fast_clk_i),
            .ext_i     (ext_clk_i[g]),
            .src_sel   (src_e'(ctrl_q[g][1:0])),
            .div_sel   (ctrl_q[g][DIV_W+1:2]),
            .clr_i     (!run[g]),
            .tick_en_o (tick_en[g])
        );
    end

    // next counter value and match pulse
    always_comb begin
        c16 = {cnt_q[1], cnt_q[0]};
        d16 = {data_q[1], data_q[0]};
        n16 = c16;
        n8  = '0;
        for (int i = 0; i < NCH; i++) begin
            cnt_nx[i] = cnt_q[i];
            irq_nx[i] = 1'b0;
        end
        if (join_w) begin
            if (run[0] && tick_en[0]) begin
                n16       = (c16 == d16) ? '0 : c16 + DW'(1);
                irq_nx[1] = (n16 == d16);
            end
            if (|wr_cnt) begin
                n16       = '0;
                irq_nx[1] = 1'b0;
            end
            cnt_nx[0] = n16[CW-1:0];
            cnt_nx[1] = n16[DW-1:CW];
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (run[i] && tick_en[i]) begin
                    n8        = (cnt_q[i] == data_q[i]) ? '0 : cnt_q[i] + CW'(1);
                    cnt_nx[i] = n8;
                    irq_nx[i] = (n8 == data_q[i]);
                end
                if (wr_cnt[i]) begin
                    cnt_nx[i] = '0;
                    irq_nx[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                ctrl_q[i] <= '0;
                data_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
            irq_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_en_i && addr_i == AW'(A_CTRL0 + i)) ctrl_q[i] <= wdata_i;
                if (wr_en_i && addr_i == AW'(A_DATA0 + i)) data_q[i] <= wdata_i;
                cnt_q[i] <= cnt_nx[i];
            end
            irq_q <= irq_nx;
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        rdata_o = '0;
        unique case (int'(addr_i))
            A_CTRL0:     rdata_o = ctrl_q[0];
            A_CTRL0 + 1: rdata_o = ctrl_q[1];
            A_DATA0:     rdata_o = data_q[0];
            A_DATA0 + 1: rdata_o = data_q[1];
            A_CNT0:      rdata_o = cnt_q[0];
            A_CNT0 + 1:  rdata_o = cnt_q[1];
            A_STATUS:    rdata_o = {{(CW-NCH){1'b0}}, run};
            default:     rdata_o = '0;
        endcase
    end

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(A_CNT0)) |=> cnt_q[0] == '0);
    p_clear_join_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == AW'(A_CNT0 + 1) && join_w) |=> (cnt_q[0] == '0 && cnt_q[1] == '0));
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !join_w && !run[0]) |=> $stable(cnt_q[0]));
    p_low_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (join_w && $past(join_w)) |-> !irq_o[0]);
    p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] |=> !irq_o[1]);
    p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run[0]) |-> $past(wr_en_i && addr_i == AW'(A_START) && wdata_i[0]));
endmodule

// File: tb/match_timer_pair_test.sv
module match_timer_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_clk = 1'b0, fast_clk = 1'b0;
    logic [1:0] ext_clk = 2'b00;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [1:0] irq;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    match_timer_pair uut (
        .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .fast_clk_i(fast_clk),
        .ext_clk_i(ext_clk), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    // source waveforms: fast period 4, slow period 16, external period 6 clocks
    int ncnt = 0;
    always @(negedge clk) begin
        ncnt++;
        if (ncnt % 2 == 0) fast_clk <= ~fast_clk;
        if (ncnt % 8 == 0) slow_clk <= ~slow_clk;
        if (ncnt % 3 == 0) ext_clk  <= ~ext_clk;
    end

    // behavioural reference model
    int m_ctrl[2], m_data[2], m_cnt[2], m_pre[2], m_run[2], m_prev[2], m_e1[2], m_e2[2], m_irq[2];

    function automatic int m_read(int a);
        case (a)
            0, 1: return m_ctrl[a];
            2, 3: return m_data[a-2];
            4, 5: return m_cnt[a-4];
            8:    return m_run[0] + 2 * m_run[1];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_ctrl[i] = 0; m_data[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
                m_run[i] = 0; m_prev[i] = 0; m_e1[i] = 0; m_e2[i] = 0; m_irq[i] = 0;
            end
        end else begin
            int sel[2], en[2], ncnt2[2], nirq[2], nrun[2];
            int jn, clr0, clr1, ex, c, d, n;
            jn = (m_ctrl[0] >> 7) & 1;
            for (int i = 0; i < 2; i++) begin
                case (m_ctrl[i] & 3)
                    1: sel[i] = fast_clk;
                    2: sel[i] = m_e2[i];
                    default: sel[i] = slow_clk;
                endcase
                ex = (m_ctrl[i] >> 2) & 7;
                if (ex > 6) ex = 0;
                en[i] = (sel[i] && !m_prev[i] && m_run[i] && (m_pre[i] % (1 << ex)) == (1 << ex) - 1);
                ncnt2[i] = m_cnt[i]; nirq[i] = 0;
            end
            clr0 = wr_en && addr == 4;
            clr1 = wr_en && addr == 5;
            if (jn) begin
                c = m_cnt[1] * 256 + m_cnt[0];
                d = m_data[1] * 256 + m_data[0];
                n = c;
                if (en[0]) begin
                    n = (c == d) ? 0 : (c + 1) % 65536;
                    nirq[1] = (n == d);
                end
                if (clr0 || clr1) begin n = 0; nirq[1] = 0; end
                ncnt2[0] = n % 256; ncnt2[1] = n / 256;
            end else begin
                for (int i = 0; i < 2; i++) begin
                    if (en[i]) begin
                        n = (m_cnt[i] == m_data[i]) ? 0 : (m_cnt[i] + 1) % 256;
                        ncnt2[i] = n; nirq[i] = (n == m_data[i]);
                    end
                    if ((i == 0 && clr0) || (i == 1 && clr1)) begin ncnt2[i] = 0; nirq[i] = 0; end
                end
            end
            for (int i = 0; i < 2; i++) begin
                nrun[i] = m_run[i];
                if (wr_en && addr == 6 && wdata[i] && !(i == 1 && jn)) nrun[i] = 1;
                if (wr_en && addr == 7 && wdata[i] && !(i == 1 && jn)) nrun[i] = 0;
                if (!m_run[i]) m_pre[i] = 0;
                else if (sel[i] && !m_prev[i]) m_pre[i] = (m_pre[i] + 1) % 64;
                m_prev[i] = sel[i];
                m_e2[i] = m_e1[i];
                m_e1[i] = ext_clk[i];
                if (wr_en && addr == i)     m_ctrl[i] = wdata;
                if (wr_en && addr == i + 2) m_data[i] = wdata;
                m_cnt[i] = ncnt2[i]; m_irq[i] = nirq[i]; m_run[i] = nrun[i];
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // continuous comparison against the model, away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R3 irq0", irq[0], m_irq[0]);
            chk("R3 irq1", irq[1], m_irq[1]);
            chk("R10 rdata", rdata, m_read(addr));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk);
        addr = 4'(a);
        @(posedge clk); #5;
        v = rdata;
    endtask

    // cycles between two consecutive pulses on channel ch
    task automatic period(int ch, output int p);
        int t0;
        do begin @(posedge clk); #5; end while (!irq[ch]);
        t0 = cyc;
        do begin @(posedge clk); #5; end while (!irq[ch]);
        p = cyc - t0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #200000000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    int v, p, lows;
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd(8, v); chk("R1 status", v, 0);
        rd(4, v); chk("R1 cnt0", v, 0);
        chk("R1 irq", irq, 0);

        // R2: fast source, divide by 1, compare 5 -> 6 edges of 4 clocks
        wr(0, 8'h01); wr(2, 5); wr(6, 1);
        period(0, p); chk("R2 period", p, 24);
        // R5: divide by 2
        wr(7, 1); wr(0, 8'h05); wr(6, 1);
        period(0, p); chk("R5 div2 period", p, 48);
        // R5: reserved code 7 divides by 1
        wr(7, 1); wr(0, 8'h1D); wr(6, 1);
        period(0, p); chk("R5 reserved div", p, 24);
        wr(7, 1);
        rd(8, v); chk("R8 stopped status", v, 0);
        rd(4, p); repeat (30) @(posedge clk); rd(4, v); chk("R8 hold", v, p);
        // R7 clear while stopped
        wr(4, 8'hAA); rd(4, v); chk("R7 clear", v, 0);

        // R4: external pin, divide by 4, compare 2 -> 3*4*6
        wr(1, 8'h0A); wr(3, 2); wr(6, 2);
        rd(8, v); chk("R8 status ch1", v, 2);
        period(1, p); chk("R4 ext period", p, 72);
        wr(7, 2);
        // R4: reserved source code acts as slow
        wr(1, 8'h03); wr(3, 1); wr(6, 2);
        period(1, p); chk("R4 reserved src", p, 32);
        wr(7, 2);

        // R6: joined, compare 0x012C -> 301 edges of 4 clocks
        wr(5, 0); wr(4, 0);
        wr(0, 8'h81); wr(2, 8'h2C); wr(3, 8'h01); wr(6, 1);
        lows = 0;
        fork
            period(1, p);
            begin
                repeat (2800) begin @(posedge clk); #5; if (irq[0]) lows++; end
            end
        join_any
        disable fork;
        chk("R6 joined period", p, 1204);
        chk("R6 low irq quiet", lows, 0);
        // R9: channel-1 stop ignored while joined
        wr(7, 2); rd(8, v); chk("R9 odd stop ignored", v, 1);
        // R7: writing high byte clears both bytes
        wr(5, 8'h55); rd(4, v); chk("R7 joined clear low", v < 2 ? 0 : v, 0);
        wr(7, 1); rd(8, v); chk("R8 pair stopped", v, 0);
        wr(6, 2); rd(8, v); chk("R9 odd start ignored", v, 0);
        rd(6, v); chk("R10 strobe reads 0", v, 0);
        rd(2, v); chk("R10 data readback", v, 8'h2C);
        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule